// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one processor's port onto a shared memory bus and gives that processor a single reservation for a conditional-store pair. A load-linked request reads one word over the bus and returns its value. At the same moment, the word address is recorded as reserved. Writes made by other agents on the bus are snooped. Any such write to the reserved word cancels the reservation.

A later store-conditional writes its data only if the reservation is still intact and names the same word. The block returns a pass or fail status to the processor. When the reservation is already gone or names a different word, the attempt fails locally and the bus is never requested. A store-conditional that is waiting for the bus gives up its request if another agent's write to the same word appears first. That write may be a competing conditional store that won arbitration. A failed attempt never causes a bus write.

The processor issues one request at a time, and only while `req_ready` is high. A bus transfer happens in a cycle where `bus_req` and `bus_gnt` are both high. The read data on `bus_rdata` is valid in that same cycle. Addresses are word addresses and are compared on all `ADDR_W` bits.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked request (`req_valid`=1 with `req_sc`=0 while `req_ready`=1) raises `bus_req` with `bus_we`=0 from the next cycle on. `bus_addr` equals the request address. In the cycle after the transfer (`bus_req`&`bus_gnt`), the block pulses `rsp_valid` with `rsp_ok`=1 and `rsp_data` equal to the `bus_rdata` value of the transfer cycle.
- R2: A completed load-linked makes its address the reservation, so a following store-conditional to that address proceeds to the bus.
- R3: Accepting a new load-linked discards any earlier reservation. A store-conditional to the earlier address then fails.
- R4: A snooped write (`snp_valid`=1) whose `snp_addr` equals the reserved address on every bit cancels the reservation. A snooped write to any other address leaves it in place.
- R5: A store-conditional (`req_sc`=1) with no reservation, or with an address different from the reserved one, responds in the next cycle with `rsp_valid`=1 and `rsp_ok`=0. `bus_req` stays low throughout.
- R6: A store-conditional that matches a live reservation raises `bus_req` with `bus_we`=1, the request address and `req_wdata`. In the cycle after the transfer, it responds with `rsp_ok`=1.
- R7: While a store-conditional waits for the grant, a snooped write to the reserved address drops `bus_req` in that same cycle. The block then responds in the next cycle with `rsp_ok`=0, and no write takes place.
- R8: Every store-conditional, whether it passes or fails, ends the reservation. A second store-conditional to the same address fails locally.
- R9: Out of reset there is no reservation, `req_ready`=1, and `bus_req` and `rsp_valid` are 0.
- R10: A snooped write to the reserved address in the same cycle that a matching store-conditional is presented makes that store-conditional fail locally.
- R11: A snooped write to the load-linked address in its own transfer cycle leaves no reservation behind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Processor request present |
| req_sc | input | 1 | 1 = store-conditional, 0 = load-linked |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Store-conditional data |
| req_ready | output | 1 | Block can accept a request this cycle |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Transfer is a write |
| bus_addr | output | ADDR_W | Transfer word address |
| bus_wdata | output | DATA_W | Transfer write data |
| bus_gnt | input | 1 | Transfer granted this cycle |
| bus_rdata | input | DATA_W | Read data in the granted cycle |
| snp_valid | input | 1 | Another agent writes this cycle |
| snp_addr | input | ADDR_W | Word address of that write |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | 1 = success |
| rsp_data | output | DATA_W | Load-linked data (0 for store-conditional) |

## Verification
On every cycle, the assertions check several rules. A bus write is only ever issued for the live reserved word, and never in a cycle where a snooped write to that word is seen. A snoop hit always removes the reservation by the next cycle. A reservation appears only after a granted read. A granted write is always followed by a success response and an empty reservation. Other behaviours depend on particular orderings: a new load-linked replacing an old reservation, the local failure with no bus activity, the lost-arbitration abort, and snoops landing in the same cycle as a request or grant. Only the bench scenarios, compared cycle by cycle against a behavioural model, can show those.

// File: rtl/llsc_pkg.sv
`timescale 1ns/1ps
package llsc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_COND = 2'd2
   } llsc_state_e;
endpackage

// File: rtl/llsc_resv.sv
`timescale 1ns/1ps
// Single reservation register with its snoop comparator.
module llsc_resv #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              set_en,
   input  logic              set_live,
   input  logic [ADDR_W-1:0] set_addr,
   input  logic              clr,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              live,
   output logic [ADDR_W-1:0] addr,
   output logic              snp_hit
);
   generate
      if (ADDR_W < 1) begin : g_bad_width
         $error("llsc_resv: ADDR_W must be at least 1");
      end
   endgenerate

   assign snp_hit = snp_valid && live && (snp_addr == addr);

   always_ff @(posedge clk) begin
      if (rst) begin
         live <= 1'b0;
         addr <= '0;
      end else if (set_en) begin
         live <= set_live;
         addr <= set_addr;
      end else if (clr || snp_hit) begin
         live <= 1'b0;
      end
   end
endmodule

// File: rtl/llsc_ctrl.sv
`timescale 1ns/1ps
// Request sequencer: accepts one request, drives the bus, returns status.
module llsc_ctrl
   import llsc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_sc,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic              resv_live,
   input  logic [ADDR_W-1:0] resv_addr,
   input  logic              resv_hit,
   output logic              resv_set,
   output logic              resv_set_live,
   output logic              resv_clr,
   output logic              rsp_valid,
   output logic              rsp_ok,
   output logic [DATA_W-1:0] rsp_data
);
   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("llsc_ctrl: DATA_W must be at least 1");
      end
   endgenerate

   llsc_state_e       state;
   logic [ADDR_W-1:0] hold_addr;
   logic [DATA_W-1:0] hold_data;

   logic accept, cond_clear, abort, load_done, cond_done;

   assign req_ready  = (state == ST_IDLE);
   assign accept     = req_ready && req_valid;
   assign cond_clear = resv_live && (resv_addr == req_addr) && !resv_hit;
   assign abort      = (state == ST_COND) && (!resv_live || resv_hit);
   assign bus_req    = (state == ST_LOAD) || ((state == ST_COND) && !abort);
   assign bus_we     = (state == ST_COND);
   assign bus_addr   = hold_addr;
   assign bus_wdata  = hold_data;
   assign load_done  = (state == ST_LOAD) && bus_gnt;
   assign cond_done  = (state == ST_COND) && !abort && bus_gnt;

   assign resv_set      = load_done;
   assign resv_set_live = !(snp_valid && (snp_addr == hold_addr));
   assign resv_clr      = (accept && (!req_sc || !cond_clear)) || abort || cond_done;

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         hold_addr <= '0;
         hold_data <= '0;
         rsp_valid <= 1'b0;
         rsp_ok    <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  hold_addr <= req_addr;
                  hold_data <= req_wdata;
                  if (!req_sc) begin
                     state <= ST_LOAD;
                  end else if (cond_clear) begin
                     state <= ST_COND;
                  end else begin
                     rsp_valid <= 1'b1;
                     rsp_ok    <= 1'b0;
                     rsp_data  <= '0;
                  end
               end
            end
            ST_LOAD: begin
               if (load_done) begin
                  state     <= ST_IDLE;
                  rsp_valid <= 1'b1;
                  rsp_ok    <= 1'b1;
                  rsp_data  <= bus_rdata;
               end
            end
            ST_COND: begin
               if (abort || cond_done) begin
                  state     <= ST_IDLE;
                  rsp_valid <= 1'b1;
                  rsp_ok    <= cond_done;
                  rsp_data  <= '0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/llsc_monitor.sv
`timescale 1ns/1ps
module llsc_monitor #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_sc,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              rsp_valid,
   output logic              rsp_ok,
   output logic [DATA_W-1:0] rsp_data
);
   logic              resv_live;
   logic [ADDR_W-1:0] resv_addr;
   logic              resv_hit;
   logic              resv_set, resv_set_live, resv_clr;

   llsc_resv #(.ADDR_W(ADDR_W)) u_resv (
      .clk       (clk),
      .rst       (rst),
      .set_en    (resv_set),
      .set_live  (resv_set_live),
      .set_addr  (bus_addr),
      .clr       (resv_clr),
      .snp_valid (snp_valid),
      .snp_addr  (snp_addr),
      .live      (resv_live),
      .addr      (resv_addr),
      .snp_hit   (resv_hit)
   );

   llsc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk           (clk),
      .rst           (rst),
      .req_valid     (req_valid),
      .req_sc        (req_sc),
      .req_addr      (req_addr),
      .req_wdata     (req_wdata),
      .req_ready     (req_ready),
      .bus_req       (bus_req),
      .bus_we        (bus_we),
      .bus_addr      (bus_addr),
      .bus_wdata     (bus_wdata),
      .bus_gnt       (bus_gnt),
      .bus_rdata     (bus_rdata),
      .snp_valid     (snp_valid),
      .snp_addr      (snp_addr),
      .resv_live     (resv_live),
      .resv_addr     (resv_addr),
      .resv_hit      (resv_hit),
      .resv_set      (resv_set),
      .resv_set_live (resv_set_live),
      .resv_clr      (resv_clr),
      .rsp_valid     (rsp_valid),
      .rsp_ok        (rsp_ok),
      .rsp_data      (rsp_data)
   );
endmodule

// File: rtl/llsc_monitor_chk.sv
`timescale 1ns/1ps
module llsc_monitor_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              snp_valid,
   input logic [ADDR_W-1:0] snp_addr,
   input logic              bus_req,
   input logic              bus_we,
   input logic              bus_gnt,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              rsp_valid,
   input logic              rsp_ok,
   input logic              resv_live,
   input logic [ADDR_W-1:0] resv_addr
);
   p_write_needs_resv_r6: assert property (@(posedge clk) disable iff (rst)
      (bus_req && bus_we) |-> (resv_live && bus_addr == resv_addr));

   p_lost_no_write_r7: assert property (@(posedge clk) disable iff (rst)
      (bus_req && bus_we) |-> !(snp_valid && snp_addr == bus_addr));

   p_snoop_clears_r4: assert property (@(posedge clk) disable iff (rst)
      (snp_valid && resv_live && snp_addr == resv_addr) |=> !resv_live);

   p_sc_ends_resv_r8: assert property (@(posedge clk) disable iff (rst)
      (bus_req && bus_gnt && bus_we) |=> (rsp_valid && rsp_ok && !resv_live));

   p_load_drops_old_r3: assert property (@(posedge clk) disable iff (rst)
      (bus_req && !bus_we) |-> !resv_live);

   p_resv_from_load_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(resv_live) |-> $past(bus_req && bus_gnt && !bus_we));
endmodule

bind llsc_monitor llsc_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .snp_valid (snp_valid),
   .snp_addr  (snp_addr),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_gnt   (bus_gnt),
   .bus_addr  (bus_addr),
   .rsp_valid (rsp_valid),
   .rsp_ok    (rsp_ok),
   .resv_live (resv_live),
   .resv_addr (resv_addr)
);

// File: tb/sim_llsc_monitor.sv
`timescale 1ns/1ps
module sim_llsc_monitor;
   localparam logic [31:0] RKEY = 32'h5A5A_0000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 0, req_sc = 0, bus_gnt = 0, snp_valid = 0;
   logic [31:0] req_addr = 0, req_wdata = 0, snp_addr = 0;
   logic        req_ready, bus_req, bus_we, rsp_valid, rsp_ok;
   logic [31:0] bus_addr, bus_wdata, bus_rdata, rsp_data;

   int    n_chk = 0, n_bad = 0;
   bit    running = 0;
   string tag = "R9";

   always #10 clk = ~clk;
   assign bus_rdata = bus_addr ^ RKEY;

   llsc_monitor u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_sc(req_sc),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
      .snp_valid(snp_valid), .snp_addr(snp_addr), .rsp_valid(rsp_valid),
      .rsp_ok(rsp_ok), .rsp_data(rsp_data)
   );

   // behavioural reference: 0 idle, 1 reading, 2 conditional write pending
   int          m_st = 0;
   bit          m_rv = 0, m_rspv = 0, m_ok = 0;
   logic [31:0] m_ra = 0, m_la = 0, m_wd = 0, m_rd = 0;

   function automatic bit m_hit();
      return snp_valid && m_rv && snp_addr == m_ra;
   endfunction
   function automatic bit m_kill();
      return m_st == 2 && (!m_rv || m_hit());
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_st = 0; m_rv = 0; m_rspv = 0; m_ok = 0; m_rd = 0;
      end else begin
         bit hit, kill;
         hit  = m_hit();
         kill = m_kill();
         m_rspv = 0;
         if (m_st == 0) begin
            if (req_valid && !req_sc) begin
               m_st = 1; m_la = req_addr; m_rv = 0;
            end else if (req_valid) begin
               if (m_rv && m_ra == req_addr && !hit) begin
                  m_st = 2; m_la = req_addr; m_wd = req_wdata;
               end else begin
                  m_rspv = 1; m_ok = 0; m_rd = 0; m_rv = 0;
               end
            end else if (hit) m_rv = 0;
         end else if (m_st == 1) begin
            if (bus_gnt) begin
               m_rspv = 1; m_ok = 1; m_rd = m_la ^ RKEY;
               m_ra = m_la; m_rv = !(snp_valid && snp_addr == m_la);
               m_st = 0;
            end
         end else begin
            if (kill || bus_gnt) begin
               m_rspv = 1; m_ok = !kill; m_rd = 0; m_rv = 0; m_st = 0;
            end
         end
      end
   end

   task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
      end
   endtask

   // compare every cycle against the reference, mid-cycle
   always @(negedge clk) begin
      #5;
      if (running && !rst) begin
         bit breq;
         breq = (m_st == 1) || (m_st == 2 && !m_kill());
         chk(tag, "req_ready", {31'd0, req_ready}, {31'd0, m_st == 0});
         chk(tag, "bus_req", {31'd0, bus_req}, {31'd0, breq});
         chk(tag, "rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rspv});
         if (breq) begin
            chk(tag, "bus_we", {31'd0, bus_we}, {31'd0, m_st == 2});
            chk(tag, "bus_addr", bus_addr, m_la);
            if (m_st == 2) chk(tag, "bus_wdata", bus_wdata, m_wd);
         end
         if (m_rspv) begin
            chk(tag, "rsp_ok", {31'd0, rsp_ok}, {31'd0, m_ok});
            chk(tag, "rsp_data", rsp_data, m_rd);
         end
      end
   end

   task automatic step(bit rv, bit sc, logic [31:0] a, logic [31:0] wd,
                       bit sv, logic [31:0] sa, bit g);
      @(negedge clk);
      req_valid = rv; req_sc = sc; req_addr = a; req_wdata = wd;
      snp_valid = sv; snp_addr = sa; bus_gnt = g;
   endtask

   task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask

   task automatic ll_do(logic [31:0] a);
      step(1, 0, a, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0, 0, 1);
      idle();
   endtask

   task automatic wait_rsp(string t, bit exp_ok);
      #5;
      if (!rsp_valid) begin @(negedge clk); #5; end
      chk(t, "response present", {31'd0, rsp_valid}, 32'd1);
      chk(t, "status", {31'd0, rsp_ok}, {31'd0, exp_ok});
   endtask

   task automatic sc_try(string t, logic [31:0] a, logic [31:0] wd, bit exp_ok);
      step(1, 1, a, wd, 0, 0, 1);
      step(0, 0, 0, 0, 0, 0, 1);
      wait_rsp(t, exp_ok);
      idle();
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      running = 1;
      #5;
      tag = "R9";
      chk("R9", "req_ready after reset", {31'd0, req_ready}, 32'd1);
      chk("R9", "bus_req after reset", {31'd0, bus_req}, 32'd0);
      chk("R9", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
      sc_try("R9", 32'h40, 32'h1, 0);

      tag = "R1";
      step(1, 0, 32'h100, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      #5 chk("R1", "read request", {30'd0, bus_req, bus_we}, 32'd2);
      step(0, 0, 0, 0, 0, 0, 1);
      idle();
      #5;
      chk("R1", "load rsp_valid", {31'd0, rsp_valid}, 32'd1);
      chk("R1", "load rsp_data", rsp_data, 32'h100 ^ RKEY);

      tag = "R6";
      step(1, 1, 32'h100, 32'hCAFE_0001, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      #5 chk("R6", "write data on bus", bus_wdata, 32'hCAFE_0001);
      step(0, 0, 0, 0, 0, 0, 1);
      wait_rsp("R6", 1);
      idle();

      tag = "R8";
      sc_try("R8", 32'h100, 32'h2, 0);

      tag = "R3";
      ll_do(32'h200);
      ll_do(32'h204);
      sc_try("R3", 32'h200, 32'h3, 0);

      tag = "R2";
      ll_do(32'h204);
      sc_try("R2", 32'h204, 32'h4, 1);

      tag = "R4";
      ll_do(32'h300);
      step(0, 0, 0, 0, 1, 32'h304, 0);
      sc_try("R4", 32'h300, 32'h5, 1);
      ll_do(32'h300);
      step(0, 0, 0, 0, 1, 32'h300, 0);
      sc_try("R4", 32'h300, 32'h6, 0);
      ll_do(32'h8000_0300);
      step(0, 0, 0, 0, 1, 32'h0000_0300, 0);
      sc_try("R4", 32'h8000_0300, 32'h7, 1);

      tag = "R5";
      ll_do(32'h400);
      sc_try("R5", 32'h404, 32'h8, 0);

      tag = "R7";
      ll_do(32'h500);
      step(1, 1, 32'h500, 32'h9, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      #5 chk("R7", "waiting write request", {31'd0, bus_req}, 32'd1);
      step(0, 0, 0, 0, 1, 32'h500, 1);
      #5 chk("R7", "request withdrawn", {31'd0, bus_req}, 32'd0);
      idle();
      #5 chk("R7", "lost status", {rsp_valid, rsp_ok}, 2'b10);

      tag = "R10";
      ll_do(32'h600);
      step(1, 1, 32'h600, 32'hA, 1, 32'h600, 1);
      step(0, 0, 0, 0, 0, 0, 1);
      wait_rsp("R10", 0);

      tag = "R11";
      step(1, 0, 32'h700, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 32'h700, 1);
      idle();
      sc_try("R11", 32'h700, 32'hB, 0);

      tag = "R4";
      for (int i = 0; i < 600; i++) begin
         logic [31:0] pick [4];
         pick[0] = 32'h10; pick[1] = 32'h14; pick[2] = 32'h18; pick[3] = 32'h8000_0010;
         step(($urandom % 3) == 0, $urandom % 2, pick[$urandom % 4], $urandom,
              ($urandom % 4) == 0, pick[$urandom % 4], $urandom % 2);
      end
      idle();
      idle();

      running = 0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule